// File: doc/BRIEF.md
# Region-Split Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation miss. Each address carries a two-bit region selector in its top bits, a 21-bit virtual page number in bits 29:9, and a byte offset in its low nine bits, since pages hold 512 bytes. Three regions are usable: a program region, a control region and a system region. The fourth region code is invalid. Every usable region has a table base and a length limit, supplied as inputs.

A system-region lookup reads one table word straight from physical memory. The program and control tables are themselves placed in system virtual space. For those two regions the walker first maps the table word's virtual location through the system table, and only then fetches the real entry. That makes two memory reads. Every walk ends with a one-cycle done pulse. The pulse carries either the frame-based physical address together with the entry's access-rights nibble and dirty flag, or a fault kind together with the virtual address that faulted.

Entries are 32-bit words. The fields the walker decodes are: valid in bit 31, access rights in bits 30:27, dirty in bit 26, and frame number in bits 20:0. Bits 25:21 belong to the operating system and are ignored.

Top module: `region_table_walker`

## Requirements
- R1: After reset the walker is idle: reqReady is 1, and done, fault, faultKind and memReqValid are 0.
- R2: Bits 31:30 select the region: 00 program, 01 control, 10 system. Code 11 ends the walk with faultKind 1 (address fault) and issues no memory request.
- R3: If the page number in bits 29:9 is greater than or equal to the selected region's 22-bit length input, the walk ends with faultKind 2 (length fault) and issues no memory request.
- R4: A system-region walk issues exactly one memory read, at sysBase + 4 × page number.
- R5: For the program and control regions, the table word's virtual address is tva = base + 4 × page number. If tva[31:30] is not 10, the walk gives faultKind 1. If tva[29:9] ≥ sysLen, it gives faultKind 2. Neither case touches memory. Otherwise the walker reads sysBase + 4 × tva[29:9], then reads {2'b00, frame of that word, tva[8:0]}, which makes two reads in total.
- R6: If bit 31 is clear in any word the walker fetches, the walk ends with faultKind 3 (page fault) and issues no further memory request.
- R7: On success fault is 0, faultKind is 0, physAddr equals {frame bits 20:0 of the final word, address bits 8:0}, protBits equals bits 30:27 of that word, and modifyBit equals bit 26.
- R8: On any fault, fault is 1 and faultVaddr equals the address that was accepted.
- R9: A request is taken only when reqValid and reqReady are both high. reqValid and reqVaddr are ignored while a walk is in progress. done is high for exactly one cycle per walk, and reqReady returns on the cycle after it.
- R10: memReqValid is a single-cycle pulse. A new memory request is never issued while an earlier one still waits for memRspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle and able to take a request |
| progBase | input | 32 | Program-region table base (system virtual) |
| progLen | input | 22 | Program-region table length in entries |
| ctrlBase | input | 32 | Control-region table base (system virtual) |
| ctrlLen | input | 22 | Control-region table length in entries |
| sysBase | input | 32 | System table base (physical) |
| sysLen | input | 22 | System table length in entries |
| memReqValid | output | 1 | Memory read request pulse |
| memReqAddr | output | 32 | Physical address of the word to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | The completed walk faulted |
| faultKind | output | 2 | 0 none, 1 address, 2 length, 3 page |
| faultVaddr | output | 32 | Virtual address of the completed walk |
| physAddr | output | 30 | Translated physical address |
| protBits | output | 4 | Access-rights field of the final entry |
| modifyBit | output | 1 | Dirty flag of the final entry |

## Verification
The two events that can fall into the same cycle are the done pulse of a finishing walk and a request offered for the next one. The bench therefore keeps reqValid high through every walk, and it swaps reqVaddr for an unrelated value while the walk is still in progress. It drops reqValid only during the done cycle. Each walk is judged on four points: the result must belong to the originally accepted address, reqReady must be low while busy, done must last a single cycle, and the memory request count and final address must match an arithmetic model. The bench varies memory latency from walk to walk and sweeps page numbers across each length boundary, including the system-length boundary reached through a process table.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 9;
  localparam int VPN_W  = 21;
  localparam int RGN_W  = VA_W - VPN_W - OFF_W;
  localparam int PFN_W  = 21;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int LEN_W  = VPN_W + 1;
  localparam int WORD_W = 32;
  localparam int PROT_W = 4;
  localparam int ENTRY_SHIFT = 2;

  localparam int VALID_BIT  = 31;
  localparam int PROT_LSB   = 27;
  localparam int MODIFY_BIT = 26;

  localparam logic [RGN_W-1:0] RGN_PROG = 2'b00;
  localparam logic [RGN_W-1:0] RGN_CTRL = 2'b01;
  localparam logic [RGN_W-1:0] RGN_SYS  = 2'b10;
  localparam logic [RGN_W-1:0] RGN_BAD  = 2'b11;

  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_ADDR   = 2'd1,
    FK_LENGTH = 2'd2,
    FK_PAGE   = 2'd3
  } faultKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walkState_t;

  typedef struct packed {
    logic       capture;
    logic       loadDirect;
    logic       loadMid;
    logic       loadLeaf;
    logic       latchEntry;
    logic       latchFault;
    faultKind_t faultKind;
  } ctrlStrobes_t;
endpackage

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [VA_W-1:0]     progBase,
  input  logic [LEN_W-1:0]    progLen,
  input  logic [VA_W-1:0]     ctrlBase,
  input  logic [LEN_W-1:0]    ctrlLen,
  input  logic [VA_W-1:0]     sysBase,
  input  logic [LEN_W-1:0]    sysLen,
  input  logic [WORD_W-1:0]   memRspData,
  output logic                isReserved,
  output logic                isSystem,
  output logic                lenViol,
  output logic                evaBadRegion,
  output logic                evaLenViol,
  output logic                entryValid,
  output logic [VA_W-1:0]     vaddrOut,
  output logic [VA_W-1:0]     memAddr,
  output logic [PA_W-1:0]     physAddr,
  output logic [PROT_W-1:0]   protBits,
  output logic                modifyBit,
  output faultKind_t          faultKind
);
  logic [VA_W-1:0]   vaddrQ;
  logic [VA_W-1:0]   memAddrQ;
  logic [OFF_W-1:0]  evaOffQ;
  logic [PA_W-1:0]   physQ;
  logic [PROT_W-1:0] protQ;
  logic              modQ;
  faultKind_t        faultQ;

  logic [RGN_W-1:0]  region;
  logic [VPN_W-1:0]  vpn;
  logic [VA_W-1:0]   selBase;
  logic [LEN_W-1:0]  selLen;
  logic [VA_W-1:0]   evaComb;
  logic [VPN_W-1:0]  evaVpn;
  logic [PFN_W-1:0]  rspPfn;
  logic [4:0]        unusedOsBits;

  assign region = vaddrQ[VA_W-1 -: RGN_W];
  assign vpn    = vaddrQ[OFF_W +: VPN_W];
  assign rspPfn = memRspData[PFN_W-1:0];
  assign unusedOsBits = memRspData[MODIFY_BIT-1:PFN_W];

  always_comb begin
    unique case (region)
      RGN_PROG: begin selBase = progBase; selLen = progLen; end
      RGN_CTRL: begin selBase = ctrlBase; selLen = ctrlLen; end
      default:  begin selBase = sysBase;  selLen = sysLen;  end
    endcase
  end

  assign isReserved   = (region == RGN_BAD);
  assign isSystem     = (region == RGN_SYS);
  assign lenViol      = ({1'b0, vpn} >= selLen);
  assign evaComb      = selBase + VA_W'({vpn, {ENTRY_SHIFT{1'b0}}});
  assign evaVpn       = evaComb[OFF_W +: VPN_W];
  assign evaBadRegion = (evaComb[VA_W-1 -: RGN_W] != RGN_SYS);
  assign evaLenViol   = ({1'b0, evaVpn} >= sysLen);
  assign entryValid   = memRspData[VALID_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ   <= '0;
      memAddrQ <= '0;
      evaOffQ  <= '0;
      physQ    <= '0;
      protQ    <= '0;
      modQ     <= 1'b0;
      faultQ   <= FK_NONE;
    end else begin
      if (strobes.capture) begin
        vaddrQ <= reqVaddr;
      end
      if (strobes.loadDirect) begin
        memAddrQ <= sysBase + VA_W'({vpn, {ENTRY_SHIFT{1'b0}}});
      end
      if (strobes.loadMid) begin
        memAddrQ <= sysBase + VA_W'({evaVpn, {ENTRY_SHIFT{1'b0}}});
        evaOffQ  <= evaComb[OFF_W-1:0];
      end
      if (strobes.loadLeaf) begin
        memAddrQ <= VA_W'({rspPfn, evaOffQ});
      end
      if (strobes.latchEntry) begin
        physQ  <= {rspPfn, vaddrQ[OFF_W-1:0]};
        protQ  <= memRspData[PROT_LSB +: PROT_W];
        modQ   <= memRspData[MODIFY_BIT];
        faultQ <= FK_NONE;
      end
      if (strobes.latchFault) begin
        faultQ <= strobes.faultKind;
      end
    end
  end

  assign vaddrOut  = vaddrQ;
  assign memAddr   = memAddrQ;
  assign physAddr  = physQ;
  assign protBits  = protQ;
  assign modifyBit = modQ;
  assign faultKind = faultQ;

  AST_ENTRY_VALID_ON_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchEntry |-> memRspData[VALID_BIT]); // R6
endmodule

// File: rtl/walk_control.sv
module walk_control
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         isReserved,
  input  logic         isSystem,
  input  logic         lenViol,
  input  logic         evaBadRegion,
  input  logic         evaLenViol,
  input  logic         memRspValid,
  input  logic         entryValid,
  output ctrlStrobes_t strobes,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         done
);
  walkState_t stateQ, stateD;
  logic       leafStageQ, leafStageD;
  logic       outstandingQ;

  always_comb begin
    stateD     = stateQ;
    leafStageD = leafStageQ;
    strobes    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.capture = 1'b1;
          stateD = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (isReserved) begin
          strobes.latchFault = 1'b1;
          strobes.faultKind  = FK_ADDR;
          stateD = ST_DONE;
        end else if (lenViol) begin
          strobes.latchFault = 1'b1;
          strobes.faultKind  = FK_LENGTH;
          stateD = ST_DONE;
        end else if (isSystem) begin
          strobes.loadDirect = 1'b1;
          leafStageD = 1'b1;
          stateD = ST_REQ;
        end else if (evaBadRegion) begin
          strobes.latchFault = 1'b1;
          strobes.faultKind  = FK_ADDR;
          stateD = ST_DONE;
        end else if (evaLenViol) begin
          strobes.latchFault = 1'b1;
          strobes.faultKind  = FK_LENGTH;
          stateD = ST_DONE;
        end else begin
          strobes.loadMid = 1'b1;
          leafStageD = 1'b0;
          stateD = ST_REQ;
        end
      end
      ST_REQ: begin
        stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (!entryValid) begin
            strobes.latchFault = 1'b1;
            strobes.faultKind  = FK_PAGE;
            stateD = ST_DONE;
          end else if (!leafStageQ) begin
            strobes.loadLeaf = 1'b1;
            leafStageD = 1'b1;
            stateD = ST_REQ;
          end else begin
            strobes.latchEntry = 1'b1;
            stateD = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        stateD = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      leafStageQ   <= 1'b0;
      outstandingQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      leafStageQ <= leafStageD;
      if (memReqValid) begin
        outstandingQ <= 1'b1;
      end else if (memRspValid) begin
        outstandingQ <= 1'b0;
      end
    end
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_REQ);
  assign done        = (stateQ == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady); // R9
  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstandingQ); // R10
endmodule

// File: rtl/region_table_walker.sv
module region_table_walker
  import walk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVaddr,
  output logic                reqReady,
  input  logic [VA_W-1:0]     progBase,
  input  logic [LEN_W-1:0]    progLen,
  input  logic [VA_W-1:0]     ctrlBase,
  input  logic [LEN_W-1:0]    ctrlLen,
  input  logic [VA_W-1:0]     sysBase,
  input  logic [LEN_W-1:0]    sysLen,
  output logic                memReqValid,
  output logic [VA_W-1:0]     memReqAddr,
  input  logic                memRspValid,
  input  logic [WORD_W-1:0]   memRspData,
  output logic                done,
  output logic                fault,
  output logic [1:0]          faultKind,
  output logic [VA_W-1:0]     faultVaddr,
  output logic [PA_W-1:0]     physAddr,
  output logic [PROT_W-1:0]   protBits,
  output logic                modifyBit
);
  ctrlStrobes_t strobes;
  logic         isReserved, isSystem, lenViol, evaBadRegion, evaLenViol, entryValid;
  faultKind_t   faultKindW;

  walk_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .isReserved   (isReserved),
    .isSystem     (isSystem),
    .lenViol      (lenViol),
    .evaBadRegion (evaBadRegion),
    .evaLenViol   (evaLenViol),
    .memRspValid  (memRspValid),
    .entryValid   (entryValid),
    .strobes      (strobes),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .done         (done)
  );

  walk_datapath datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqVaddr     (reqVaddr),
    .progBase     (progBase),
    .progLen      (progLen),
    .ctrlBase     (ctrlBase),
    .ctrlLen      (ctrlLen),
    .sysBase      (sysBase),
    .sysLen       (sysLen),
    .memRspData   (memRspData),
    .isReserved   (isReserved),
    .isSystem     (isSystem),
    .lenViol      (lenViol),
    .evaBadRegion (evaBadRegion),
    .evaLenViol   (evaLenViol),
    .entryValid   (entryValid),
    .vaddrOut     (faultVaddr),
    .memAddr      (memReqAddr),
    .physAddr     (physAddr),
    .protBits     (protBits),
    .modifyBit    (modifyBit),
    .faultKind    (faultKindW)
  );

  assign faultKind = faultKindW;
  assign fault     = (faultKindW != FK_NONE);

  AST_NO_MEM_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReqValid); // R10
endmodule

// File: tb/region_table_walker_tb.sv
`timescale 1ns/1ps
module region_table_walker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady;
  logic [31:0] progBase, ctrlBase, sysBase;
  logic [21:0] progLen, ctrlLen, sysLen;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        done, fault;
  logic [1:0]  faultKind;
  logic [31:0] faultVaddr;
  logic [29:0] physAddr;
  logic [3:0]  protBits;
  logic        modifyBit;

  int checks = 0;
  int errors = 0;
  int memLat = 1;
  int reqCount = 0;
  int pend = 0;
  logic [31:0] pendAddr = '0;
  logic [31:0] lastReqAddr = '0;
  logic        prevReq = 1'b0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  region_table_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr), .reqReady(reqReady),
    .progBase(progBase), .progLen(progLen), .ctrlBase(ctrlBase), .ctrlLen(ctrlLen),
    .sysBase(sysBase), .sysLen(sysLen), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done), .fault(fault),
    .faultKind(faultKind), .faultVaddr(faultVaddr), .physAddr(physAddr),
    .protBits(protBits), .modifyBit(modifyBit)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic valid;
    valid = ((a[9:2] % 8'd7) != 8'd3);
    return {valid, a[5:2], a[3], 5'h15, a[22:2] ^ 21'h15555};
  endfunction

  // memory responder: one-cycle request seen at negedge, answered memLat cycles later
  always @(negedge clk) begin
    memRspValid <= 1'b0;
    if (pend > 0) begin
      if (pend == 1) begin
        memRspValid <= 1'b1;
        memRspData  <= memWord(pendAddr);
      end
      pend <= pend - 1;
    end
    if (memReqValid) begin
      check(pend == 0, "R10 outstanding", 32'(pend), 32'd0);
      check(!prevReq, "R10 pulse", {31'd0, prevReq}, 32'd0);
      pend        <= memLat;
      pendAddr    <= memReqAddr;
      lastReqAddr <= memReqAddr;
      reqCount    <= reqCount + 1;
    end
    prevReq <= memReqValid;
  end

  task automatic model(input logic [31:0] va, output logic [1:0] kind, output logic [29:0] pa,
                       output logic [3:0] prot, output logic modf, output int nReq,
                       output logic [31:0] lastAddr);
    logic [1:0]  rgn;
    logic [20:0] vpn;
    logic [31:0] base, tva, w1, w2, a1, a2;
    logic [21:0] len;
    rgn = va[31:30];
    vpn = va[29:9];
    kind = 2'd0; pa = '0; prot = '0; modf = 1'b0; nReq = 0; lastAddr = '0;
    base = (rgn == 2'b00) ? progBase : (rgn == 2'b01) ? ctrlBase : sysBase;
    len  = (rgn == 2'b00) ? progLen  : (rgn == 2'b01) ? ctrlLen  : sysLen;
    if (rgn == 2'b11) begin
      kind = 2'd1; return;
    end
    if ({1'b0, vpn} >= len) begin
      kind = 2'd2; return;
    end
    if (rgn == 2'b10) begin
      a2 = sysBase + {9'd0, vpn, 2'b00};
      nReq = 1; lastAddr = a2;
    end else begin
      tva = base + {9'd0, vpn, 2'b00};
      if (tva[31:30] != 2'b10) begin kind = 2'd1; return; end
      if ({1'b0, tva[29:9]} >= sysLen) begin kind = 2'd2; return; end
      a1 = sysBase + {9'd0, tva[29:9], 2'b00};
      w1 = memWord(a1);
      nReq = 1; lastAddr = a1;
      if (!w1[31]) begin kind = 2'd3; return; end
      a2 = {2'b00, w1[20:0], tva[8:0]};
      nReq = 2; lastAddr = a2;
    end
    w2 = memWord(a2);
    if (!w2[31]) begin kind = 2'd3; return; end
    pa = {w2[20:0], va[8:0]};
    prot = w2[30:27];
    modf = w2[26];
  endtask

  task automatic runWalk(input logic [31:0] va);
    logic [1:0]  eKind;
    logic [29:0] ePa;
    logic [3:0]  eProt;
    logic        eMod;
    int          eReq;
    logic [31:0] eLast;
    string       tag;
    int          cyc;
    model(va, eKind, ePa, eProt, eMod, eReq, eLast);
    if (va[31:30] == 2'b11) tag = "R2";
    else if (eKind == 2'd2) tag = "R3";
    else if (eKind == 2'd3) tag = "R6";
    else if (va[31:30] == 2'b10) tag = "R4";
    else tag = "R5";
    @(negedge clk);
    check(reqReady == 1'b1, "R9 ready before request", {31'd0, reqReady}, 32'd1);
    reqCount = 0;
    reqVaddr = va;
    reqValid = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b0, "R9 busy after accept", {31'd0, reqReady}, 32'd0);
    reqVaddr = ~va;   // a request held during the walk must be ignored
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R9 walk completes", {31'd0, done}, 32'd1);
    reqValid = 1'b0;
    check(faultKind == eKind, tag, {30'd0, faultKind}, {30'd0, eKind});
    check(reqCount == eReq, {tag, " memory reads"}, 32'(reqCount), 32'(eReq));
    if (eReq > 0)
      check(lastReqAddr == eLast, {tag, " last address"}, lastReqAddr, eLast);
    if (eKind == 2'd0) begin
      check(fault == 1'b0 && physAddr == ePa, "R7 physAddr", {2'd0, physAddr}, {2'd0, ePa});
      check(protBits == eProt && modifyBit == eMod, "R7 prot/modify",
            {27'd0, protBits, modifyBit}, {27'd0, eProt, eMod});
    end else begin
      check(fault == 1'b1 && faultVaddr == va, "R8 faultVaddr", faultVaddr, va);
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", {31'd0, done}, 32'd0);
    check(reqReady == 1'b1, "R9 idle after done", {31'd0, reqReady}, 32'd1);
    check(reqCount == eReq, "R9 no extra walk", 32'(reqCount), 32'(eReq));
  endtask

  function automatic logic [31:0] mkVa(input logic [1:0] r, input logic [20:0] vpn);
    logic [8:0] off;
    off = 9'((vpn * 37 + 11) % 512);
    return {r, vpn, off};
  endfunction

  initial begin
    int n;
    progBase = 32'h8000_0400; progLen = 22'd40;
    ctrlBase = 32'h8000_7C00; ctrlLen = 22'd400;
    sysBase  = 32'h0000_2000; sysLen  = 22'd64;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && done == 1'b0, "R1 reset idle", {30'd0, reqReady, done}, 32'd2);
    check(memReqValid == 1'b0 && fault == 1'b0 && faultKind == 2'd0, "R1 reset outputs",
          {29'd0, memReqValid, faultKind}, 32'd0);
    rstN = 1'b1;
    n = 0;
    for (int v = 0; v <= 42; v++) begin memLat = 1 + (n++ % 3); runWalk(mkVa(2'b00, 21'(v))); end
    for (int v = 0; v <= 402; v += 3) begin memLat = 1 + (n++ % 3); runWalk(mkVa(2'b01, 21'(v))); end
    for (int v = 0; v <= 66; v++) begin memLat = 1 + (n++ % 3); runWalk(mkVa(2'b10, 21'(v))); end
    for (int r = 0; r < 4; r++) begin
      runWalk(mkVa(2'(r), 21'h1FFFFF));
      runWalk(mkVa(2'(r), 21'd0));
    end
    // R5: process tables placed outside system space
    progBase = 32'h0000_0000;
    ctrlBase = 32'hC000_0000;
    for (int v = 0; v < 6; v++) begin
      runWalk(mkVa(2'b00, 21'(v)));
      runWalk(mkVa(2'b01, 21'(v)));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule